// File: doc/BRIEF.md
# Sliding Window Register Mapper

This block turns the logical floating-point register numbers carried in instruction fields into physical indices of a 160-entry register file. The physical file has two parts. Indices 0 to 127 form a window area. Indices 128 to 159 form a global bank that never moves. The window area is itself split in two. A fixed region at the bottom has a selectable size of 4, 8, 16 or 32 registers. The rest of the window area is a rotating region, and its mapping is offset by a window base and wraps around. The fixed region and the rotating region always add up to 128 registers.

Software loads the fixed-region size and the base through a configuration port. Slide commands advance the base, and the advance wraps modulo the size of the rotating region. Three lookup lanes translate logical numbers combinationally in every cycle. A lane flags a number as illegal when that number is out of range, or when a normal instruction names a register that only extended instructions may use. An illegal lane returns physical index 0. Register storage, decode and hazard handling are done elsewhere.

Top module: `fpr_window_map`

## Requirements
- R1: After reset the fixed-size code is 3 (32 fixed registers) and the base is 0, so every logical number from 0 to 159 maps to the same physical number.
- R2: A logical number below the fixed size F maps to the same physical number, whatever the base.
- R3: A logical number L with F <= L <= 127 maps to F + ((L - F + base) mod (128 - F)). The result always lies from F to 127.
- R4: A logical number from 128 to 159 maps to the same physical number.
- R5: When a lookup has its extended flag clear (a normal instruction), logical numbers 32 and above are illegal. The illegal flag goes to 1 and the index goes to 0. With the extended flag set, numbers from 0 to 159 are legal.
- R6: A logical number of 160 or more is always illegal, and its index is 0.
- R7: A configuration write loads the size code (0, 1, 2, 3 select F = 4, 8, 16, 32) and the base, reduced modulo 128 - F. Both take effect from the next cycle.
- R8: A slide command adds its amount (0 to 127) to the base modulo 128 - F, from the next cycle. A lookup in the same cycle as the command uses the old base. With no command, the base and size hold.
- R9: When a configuration write and a slide arrive in the same cycle, the configuration write wins.
- R10: A lane whose valid input is 0 outputs valid 0, index 0 and illegal 0.
- R11: The stored base is always below 128 - F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_fix_sel | input | 2 | Fixed-size code (F = 4 << code) |
| cfg_base | input | 7 | Base value to load |
| slide_en | input | 1 | Slide command strobe |
| slide_amt | input | 7 | Amount added to the base |
| lk_ext | input | 1 | Lookups belong to an extended instruction |
| lk_valid | input | 3 | Per-lane lookup valid |
| lk_lidx | input | 3x8 | Per-lane logical register number |
| pk_valid | output | 3 | Per-lane result valid |
| pk_pidx | output | 3x8 | Per-lane physical index |
| pk_illegal | output | 3 | Per-lane illegal flag |

## Verification
Assertions check the following on every cycle: the base stays inside the rotating span, an illegal lane returns index 0, an idle lane stays quiet, and the fixed, global and rotating regions each land in their own physical range. The same assertions check that an idle cycle leaves the state unchanged. The exact rotated index for a given base, the wrap at the span boundary, the old-base rule when a slide and a lookup share a cycle, and the priority of a configuration write over a slide are shown only by the bench's scenarios, where the expected numbers are worked out by hand.

// File: rtl/fpr_window_pkg.sv
package fpr_window_pkg;

  typedef enum logic [1:0] {
    RG_FIXED  = 2'd0,
    RG_SLIDE  = 2'd1,
    RG_GLOBAL = 2'd2,
    RG_OOR    = 2'd3
  } region_e;

  // fixed-region size selected by a size code
  function automatic int unsigned fix_of(input int unsigned code, input int unsigned fix_min);
    return fix_min << code;
  endfunction

  // reduce a sum that is known to be below three spans
  function automatic int unsigned wrap3(input int unsigned sum, input int unsigned span);
    int unsigned s;
    s = sum;
    if (s >= 2 * span) s = s - 2 * span;
    if (s >= span) s = s - span;
    return s;
  endfunction

endpackage

// File: rtl/fpr_window_state.sv
module fpr_window_state
  import fpr_window_pkg::*;
#(
  parameter int unsigned SLIDE_REGS = 128,
  parameter int unsigned FIX_MIN    = 4,
  parameter int unsigned CODE_W     = 2,
  parameter int unsigned BASE_W     = $clog2(SLIDE_REGS),
  parameter int unsigned PIDX_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CODE_W-1:0] cfg_fix_sel,
  input  logic [BASE_W-1:0] cfg_base,
  input  logic              slide_en,
  input  logic [BASE_W-1:0] slide_amt,
  output logic [PIDX_W-1:0] fix_size,
  output logic [BASE_W-1:0] base
);

  localparam logic [CODE_W-1:0] CODE_RST = '1;

  logic [CODE_W-1:0] code_q;
  logic [BASE_W-1:0] base_q;
  logic [PIDX_W-1:0] span_cur;
  logic [PIDX_W-1:0] span_new;
  logic              ev_cfg;
  logic              ev_slide;
  logic [BASE_W-1:0] base_cfg_red;
  logic [BASE_W-1:0] base_slid;

  assign ev_cfg   = cfg_we;
  assign ev_slide = slide_en && !cfg_we;

  assign fix_size = PIDX_W'(fix_of(int'(code_q), FIX_MIN));
  assign span_cur = PIDX_W'(SLIDE_REGS - fix_of(int'(code_q), FIX_MIN));
  assign span_new = PIDX_W'(SLIDE_REGS - fix_of(int'(cfg_fix_sel), FIX_MIN));

  assign base_cfg_red = BASE_W'(wrap3(int'(cfg_base), int'(span_new)));
  assign base_slid    = BASE_W'(wrap3(int'(base_q) + int'(slide_amt), int'(span_cur)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= CODE_RST;
      base_q <= '0;
    end else if (ev_cfg) begin
      code_q <= cfg_fix_sel;
      base_q <= base_cfg_red;
    end else if (ev_slide) begin
      base_q <= base_slid;
    end
  end

  assign base = base_q;

  AST_BASE_IN_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    PIDX_W'(base_q) < span_cur); // R11

  AST_CFG_LOADS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> code_q == $past(cfg_fix_sel)); // R7

  AST_CFG_BEATS_SLIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && slide_en && (PIDX_W'(cfg_base) < span_new)) |=> base_q == $past(cfg_base)); // R9

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && !slide_en) |=> ($stable(base_q) && $stable(code_q))); // R8

endmodule

// File: rtl/fpr_window_lane.sv
module fpr_window_lane
  import fpr_window_pkg::*;
#(
  parameter int unsigned SLIDE_REGS  = 128,
  parameter int unsigned GLOBAL_REGS = 32,
  parameter int unsigned NORMAL_REGS = 32,
  parameter int unsigned BASE_W      = 7,
  parameter int unsigned PIDX_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIDX_W-1:0] fix_size,
  input  logic [BASE_W-1:0] base,
  input  logic              ext,
  input  logic              valid,
  input  logic [PIDX_W-1:0] lidx,
  output logic              o_valid,
  output logic [PIDX_W-1:0] o_pidx,
  output logic              o_illegal
);

  localparam int unsigned TOTAL = SLIDE_REGS + GLOBAL_REGS;

  region_e           region;
  logic              ext_only;
  logic              illegal;
  logic [PIDX_W-1:0] span;
  logic [PIDX_W-1:0] rot_idx;
  logic [PIDX_W-1:0] pidx;

  always_comb begin
    if (int'(lidx) >= TOTAL)            region = RG_OOR;
    else if (int'(lidx) >= SLIDE_REGS)  region = RG_GLOBAL;
    else if (lidx >= fix_size)          region = RG_SLIDE;
    else                                region = RG_FIXED;
  end

  assign ext_only = int'(lidx) >= NORMAL_REGS;
  assign illegal  = valid && ((region == RG_OOR) || (ext_only && !ext));
  assign span     = PIDX_W'(SLIDE_REGS) - fix_size;
  assign rot_idx  = fix_size +
                    PIDX_W'(wrap3(int'(lidx - fix_size) + int'(base), int'(span)));

  always_comb begin
    pidx = '0;
    if (valid && !illegal) begin
      case (region)
        RG_SLIDE: pidx = rot_idx;
        default:  pidx = lidx;
      endcase
    end
  end

  assign o_valid   = valid;
  assign o_pidx    = pidx;
  assign o_illegal = illegal;

  AST_FIXED_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !illegal && region == RG_FIXED) |-> o_pidx == lidx); // R2

  AST_ROTATE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !illegal && region == RG_SLIDE) |->
      (o_pidx >= fix_size && int'(o_pidx) < SLIDE_REGS)); // R3

  AST_GLOBAL_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !illegal && region == RG_GLOBAL) |-> o_pidx == lidx); // R4

  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    o_illegal |-> o_pidx == '0); // R5

  AST_OOR_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && int'(lidx) >= TOTAL) |-> o_illegal); // R6

  AST_IDLE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (!o_valid && !o_illegal && o_pidx == '0)); // R10

endmodule

// File: rtl/fpr_window_map.sv
module fpr_window_map
  import fpr_window_pkg::*;
#(
  parameter int unsigned SLIDE_REGS  = 128,
  parameter int unsigned GLOBAL_REGS = 32,
  parameter int unsigned NORMAL_REGS = 32,
  parameter int unsigned FIX_MIN     = 4,
  parameter int unsigned CODE_W      = 2,
  parameter int unsigned LANES       = 3,
  parameter int unsigned BASE_W      = $clog2(SLIDE_REGS),
  parameter int unsigned PIDX_W      = $clog2(SLIDE_REGS + GLOBAL_REGS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [CODE_W-1:0]            cfg_fix_sel,
  input  logic [BASE_W-1:0]            cfg_base,
  input  logic                         slide_en,
  input  logic [BASE_W-1:0]            slide_amt,
  input  logic                         lk_ext,
  input  logic [LANES-1:0]             lk_valid,
  input  logic [LANES-1:0][PIDX_W-1:0] lk_lidx,
  output logic [LANES-1:0]             pk_valid,
  output logic [LANES-1:0][PIDX_W-1:0] pk_pidx,
  output logic [LANES-1:0]             pk_illegal
);

  logic [PIDX_W-1:0] fix_size;
  logic [BASE_W-1:0] base;

  fpr_window_state #(
    .SLIDE_REGS(SLIDE_REGS),
    .FIX_MIN   (FIX_MIN),
    .CODE_W    (CODE_W),
    .BASE_W    (BASE_W),
    .PIDX_W    (PIDX_W)
  ) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_fix_sel(cfg_fix_sel),
    .cfg_base   (cfg_base),
    .slide_en   (slide_en),
    .slide_amt  (slide_amt),
    .fix_size   (fix_size),
    .base       (base)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    fpr_window_lane #(
      .SLIDE_REGS (SLIDE_REGS),
      .GLOBAL_REGS(GLOBAL_REGS),
      .NORMAL_REGS(NORMAL_REGS),
      .BASE_W     (BASE_W),
      .PIDX_W     (PIDX_W)
    ) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .fix_size (fix_size),
      .base     (base),
      .ext      (lk_ext),
      .valid    (lk_valid[g]),
      .lidx     (lk_lidx[g]),
      .o_valid  (pk_valid[g]),
      .o_pidx   (pk_pidx[g]),
      .o_illegal(pk_illegal[g])
    );
  end

endmodule

// File: tb/fpr_window_map_tb.sv
`timescale 1ns/1ps
module fpr_window_map_tb;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_we = 1'b0;
  logic [1:0]       cfg_fix_sel = '0;
  logic [6:0]       cfg_base = '0;
  logic             slide_en = 1'b0;
  logic [6:0]       slide_amt = '0;
  logic             lk_ext = 1'b0;
  logic [2:0]       lk_valid = '0;
  logic [2:0][7:0]  lk_lidx = '0;
  logic [2:0]       pk_valid;
  logic [2:0][7:0]  pk_pidx;
  logic [2:0]       pk_illegal;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  fpr_window_map u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_fix_sel(cfg_fix_sel),
    .cfg_base(cfg_base), .slide_en(slide_en), .slide_amt(slide_amt),
    .lk_ext(lk_ext), .lk_valid(lk_valid), .lk_lidx(lk_lidx),
    .pk_valid(pk_valid), .pk_pidx(pk_pidx), .pk_illegal(pk_illegal)
  );

  // {size code, base, ext, logical, expected physical, expected illegal, requirement}
  localparam int NV = 18;
  localparam logic [30:0] VEC [NV] = '{
    {2'd3, 7'd0,   1'b1, 8'd40,  8'd40,  1'b0, 4'd3},
    {2'd3, 7'd5,   1'b1, 8'd40,  8'd45,  1'b0, 4'd3},
    {2'd3, 7'd90,  1'b1, 8'd127, 8'd121, 1'b0, 4'd3},
    {2'd3, 7'd90,  1'b1, 8'd10,  8'd10,  1'b0, 4'd2},
    {2'd3, 7'd90,  1'b1, 8'd130, 8'd130, 1'b0, 4'd4},
    {2'd3, 7'd90,  1'b0, 8'd130, 8'd0,   1'b1, 4'd5},
    {2'd3, 7'd5,   1'b0, 8'd20,  8'd20,  1'b0, 4'd2},
    {2'd0, 7'd2,   1'b1, 8'd5,   8'd7,   1'b0, 4'd3},
    {2'd0, 7'd2,   1'b1, 8'd127, 8'd5,   1'b0, 4'd3},
    {2'd0, 7'd4,   1'b0, 8'd30,  8'd34,  1'b0, 4'd5},
    {2'd0, 7'd4,   1'b0, 8'd32,  8'd0,   1'b1, 4'd5},
    {2'd0, 7'd4,   1'b1, 8'd3,   8'd3,   1'b0, 4'd2},
    {2'd1, 7'd119, 1'b1, 8'd8,   8'd127, 1'b0, 4'd3},
    {2'd1, 7'd119, 1'b1, 8'd9,   8'd8,   1'b0, 4'd3},
    {2'd2, 7'd111, 1'b1, 8'd16,  8'd127, 1'b0, 4'd3},
    {2'd2, 7'd100, 1'b1, 8'd50,  8'd38,  1'b0, 4'd3},
    {2'd3, 7'd0,   1'b1, 8'd160, 8'd0,   1'b1, 4'd6},
    {2'd3, 7'd100, 1'b1, 8'd32,  8'd36,  1'b0, 4'd7}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] code, input logic [6:0] b);
    @(negedge clk);
    cfg_we = 1'b1; cfg_fix_sel = code; cfg_base = b;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic slide(input logic [6:0] amt);
    @(negedge clk);
    slide_en = 1'b1; slide_amt = amt;
    @(negedge clk);
    slide_en = 1'b0;
  endtask

  // single lookup on lane 0, returns index and illegal flag
  task automatic look(input logic ext, input logic [7:0] l, output logic [7:0] p, output logic il);
    lk_ext = ext; lk_valid = 3'b001; lk_lidx[0] = l;
    #1;
    p = pk_pidx[0]; il = pk_illegal[0];
  endtask

  initial begin
    #150000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] p;
    logic       il;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state: code 3, base 0 -> identity
    @(negedge clk);
    look(1'b1, 8'd40, p, il);  check("R1", p, 8'd40);
    look(1'b1, 8'd127, p, il); check("R1", p, 8'd127);
    look(1'b1, 8'd159, p, il); check("R1", p, 8'd159);

    // table walk, each entry on its own lane, the others idle
    for (int i = 0; i < NV; i++) begin
      logic [30:0] v;
      int ln;
      string rq;
      v = VEC[i];
      ln = i % 3;
      rq = $sformatf("R%0d", v[3:0]);
      cfg(v[30:29], v[28:22]);
      lk_ext = v[21]; lk_valid = '0; lk_valid[ln] = 1'b1;
      lk_lidx = '{default: 8'd77};
      lk_lidx[ln] = v[20:13];
      #1;
      check(rq, pk_pidx[ln], v[12:5]);
      check(rq, {7'd0, pk_illegal[ln]}, {7'd0, v[4]});
      for (int k = 0; k < 3; k++) begin
        if (k != ln) begin
          check("R10", {pk_illegal[k], pk_valid[k]} == 2'b00 ? pk_pidx[k] : 8'hff, 8'd0);
        end
      end
    end

    // R6 far out of range, extended
    look(1'b1, 8'd200, p, il); check("R6", {7'd0, il}, 8'd1); check("R6", p, 8'd0);

    // R8 slide with same-cycle lookup uses old base
    cfg(2'd3, 7'd0);
    slide_en = 1'b1; slide_amt = 7'd10;
    look(1'b1, 8'd32, p, il); check("R8", p, 8'd32);
    @(negedge clk);
    slide_en = 1'b0;
    look(1'b1, 8'd32, p, il); check("R8", p, 8'd42);
    // R8 hold with no command
    repeat (3) @(negedge clk);
    look(1'b1, 8'd32, p, il); check("R8", p, 8'd42);

    // R8 slide wrap: base 90 + 10 = 100 -> 4 (span 96)
    cfg(2'd3, 7'd90);
    slide(7'd10);
    look(1'b1, 8'd32, p, il); check("R8", p, 8'd36);
    // R11 large amount: 95 + 127 = 222 -> 30
    cfg(2'd3, 7'd95);
    slide(7'd127);
    look(1'b1, 8'd32, p, il); check("R11", p, 8'd62);
    // small span region: fix 4 span 124, base 120 + 10 -> 6
    cfg(2'd0, 7'd120);
    slide(7'd10);
    look(1'b1, 8'd4, p, il); check("R8", p, 8'd10);

    // R9 config beats a simultaneous slide
    @(negedge clk);
    cfg_we = 1'b1; cfg_fix_sel = 2'd3; cfg_base = 7'd7;
    slide_en = 1'b1; slide_amt = 7'd50;
    @(negedge clk);
    cfg_we = 1'b0; slide_en = 1'b0;
    look(1'b1, 8'd32, p, il); check("R9", p, 8'd39);

    // R10 all lanes idle
    lk_valid = '0; lk_lidx = '{default: 8'd200};
    #1;
    check("R10", {5'd0, pk_valid}, 8'd0);
    check("R10", {5'd0, pk_illegal}, 8'd0);
    check("R10", pk_pidx[1], 8'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule